// File: doc/BRIEF.md
# Banked Gamma and Common-Voltage Code Controller

This block is the digital core of an eleven-channel reference buffer: ten gamma channels and one common-voltage channel. Every channel owns four stored 8-bit codes, one per bank, and one volatile direct code. A two-bit mode field decides where each channel's code comes from. It can come from a bank picked by two external select pins, from a bank picked by a software select register, or from the channel's direct register. The selected codes pass through an output holding stage that a load input controls. While load is high the stage is transparent. When load falls the stage captures the current codes, and it keeps them until load rises again.

A synchronous request port stands in for the serial configuration bus. It loads the bank array, the direct registers, the soft select register and the control register, and it reads all of them back. The request side uses valid/ready. `req_ready` is always high, so a request is accepted on every cycle that `req_valid` is high. A read answers exactly one cycle later with a one-cycle `rsp_valid` pulse, and the response cannot be stalled. The load input and the select pins are asynchronous and pass through two-flop synchronizers. All eleven held codes are presented in parallel on `code_out`.

Top module: `gamma_bank_ctrl`

## Requirements
- R1: After reset every channel of `code_out` is 0, the control field is 0 (pin-driven bank selection), the soft select register is 0 (bank A), and all stored codes read back as 0.
- R2: The control register at address 60h keeps write-data bits [1:0], and reads of it return 0 in bits [7:2]. With bit 1 clear, pin mode applies whatever bit 0 is. The value 2 selects soft mode and the value 3 selects direct mode.
- R3: A bank is coded as the two-bit value {S1,S0}: 0 is A, 1 is B, 2 is C and 3 is D. The code for channel n (0..10) in bank b sits at address 10h + 4n + b.
- R4: In pin mode each channel shows its code from the bank coded on `bank_pin`, and the soft select register has no effect.
- R5: In soft mode the bank comes from the soft register at address 50h (bit 0 is S0, bit 1 is S1), and `bank_pin` has no effect. Reads of 50h return 0 in bits [7:2].
- R6: In direct mode channel n shows its direct register at address 0h + n (00h..0Ah), whatever the bank selection.
- R7: While load is high, `code_out` follows the selected codes. A change on `bank_pin` or `load_in` shows on `code_out` at the third rising clock edge after it, and not before.
- R8: While the synchronized load is low, `code_out` does not change, whatever happens on the pins or in the registers.
- R9: The codes selected when load falls are the ones held. After load rises, `code_out` again takes the current selection.
- R10: `req_ready` is always 1. A write takes effect at the edge that accepts it. A read returns the stored byte, with `rsp_valid` high, exactly one cycle after it is accepted.
- R11: Addresses outside the mapped windows (for example 0Bh..0Fh, 3Ch..4Fh, 70h) read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_in | input | 1 | Asynchronous load control: high is transparent, low holds |
| bank_pin | input | 2 | Asynchronous bank select pins {S1,S0} |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready, always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_data | output | 8 | Read response data |
| code_out | output | 88 | Held codes, channel n in bits [8n+7:8n] |

## Verification
The assertions assume that the environment can always take a response, because nothing stalls `rsp_valid`, and that the held codes move only through the synchronized load path. They also assume that a read of an unmapped or partly implemented address is decided by the address on the cycle the read is accepted. The stimulus changes inputs only at falling clock edges, and it holds `load_in` and `bank_pin` steady for several cycles after each change so the synchronizers settle. It issues one request at a time, and reads every stored location only after writing it.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
  typedef enum logic [1:0] {
    SRC_PIN    = 2'd0,
    SRC_SOFT   = 2'd1,
    SRC_DIRECT = 2'd2
  } src_e;

  // Bit 1 clear: pin selection whatever bit 0 holds.
  function automatic src_e decode_mode(input logic [1:0] mode_bits);
    if (!mode_bits[1])     return SRC_PIN;
    else if (!mode_bits[0]) return SRC_SOFT;
    else                    return SRC_DIRECT;
  endfunction
endpackage

// File: rtl/gbc_sync.sv
module gbc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gbc_regfile.sv
module gbc_regfile #(
  parameter int NCH         = 11,
  parameter int CW          = 8,
  parameter int NBANK       = 4,
  parameter int AW          = 8,
  parameter int DIRECT_BASE = 'h00,
  parameter int BANK_BASE   = 'h10,
  parameter int SOFT_ADDR   = 'h50,
  parameter int CTRL_ADDR   = 'h60,
  localparam int NENT       = NCH * NBANK,
  localparam int BW         = $clog2(NBANK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [CW-1:0]       req_wdata,
  output logic                rsp_valid,
  output logic [CW-1:0]       rsp_data,
  output logic [NENT*CW-1:0]  bank_flat,
  output logic [NCH*CW-1:0]   direct_flat,
  output logic [BW-1:0]       soft_sel,
  output logic [1:0]          mode_bits
);
  logic wr_fire, rd_fire;
  assign wr_fire = req_valid && req_write;
  assign rd_fire = req_valid && !req_write;

  generate
    for (genvar e = 0; e < NENT; e++) begin : g_bank
      logic [CW-1:0] q;
      logic          hit;
      assign hit = wr_fire && (req_addr == AW'(BANK_BASE + e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= req_wdata;
      end
      assign bank_flat[e*CW +: CW] = q;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_direct
      logic [CW-1:0] q;
      logic          hit;
      assign hit = wr_fire && (req_addr == AW'(DIRECT_BASE + n));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= req_wdata;
      end
      assign direct_flat[n*CW +: CW] = q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_sel  <= '0;
      mode_bits <= '0;
    end else if (wr_fire) begin
      if (req_addr == AW'(SOFT_ADDR)) soft_sel  <= req_wdata[BW-1:0];
      if (req_addr == AW'(CTRL_ADDR)) mode_bits <= req_wdata[1:0];
    end
  end

  logic [CW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int e = 0; e < NENT; e++)
      if (req_addr == AW'(BANK_BASE + e)) rd_val = bank_flat[e*CW +: CW];
    for (int n = 0; n < NCH; n++)
      if (req_addr == AW'(DIRECT_BASE + n)) rd_val = direct_flat[n*CW +: CW];
    if (req_addr == AW'(SOFT_ADDR)) rd_val = CW'(soft_sel);
    if (req_addr == AW'(CTRL_ADDR)) rd_val = CW'(mode_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= rd_val;
    end
  end
endmodule

// File: rtl/gbc_select.sv
module gbc_select
  import gbc_pkg::*;
#(
  parameter int NCH   = 11,
  parameter int CW    = 8,
  parameter int NBANK = 4,
  localparam int NENT = NCH * NBANK,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic [1:0]          mode_bits,
  input  logic [BW-1:0]       pin_sel,
  input  logic [BW-1:0]       soft_sel,
  input  logic [NENT*CW-1:0]  bank_flat,
  input  logic [NCH*CW-1:0]   direct_flat,
  output logic [NCH*CW-1:0]   sel_flat
);
  src_e          src;
  logic [BW-1:0] bank_idx;

  assign src      = decode_mode(mode_bits);
  assign bank_idx = (src == SRC_SOFT) ? soft_sel : pin_sel;

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic [CW-1:0] bank_code;
      always_comb begin
        bank_code = '0;
        for (int b = 0; b < NBANK; b++)
          if (bank_idx == BW'(b)) bank_code = bank_flat[(n*NBANK+b)*CW +: CW];
      end
      assign sel_flat[n*CW +: CW] =
        (src == SRC_DIRECT) ? direct_flat[n*CW +: CW] : bank_code;
    end
  endgenerate
endmodule

// File: rtl/gbc_hold.sv
module gbc_hold #(
  parameter int NCH = 11,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_s,
  input  logic [NCH*CW-1:0] sel_flat,
  output logic [NCH*CW-1:0] code_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_flat <= '0;
    else if (load_s) code_flat <= sel_flat;
  end
endmodule

// File: rtl/gamma_bank_ctrl.sv
module gamma_bank_ctrl #(
  parameter int NCH         = 11,
  parameter int CW          = 8,
  parameter int NBANK       = 4,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIRECT_BASE = 'h00,
  parameter int BANK_BASE   = 'h10,
  parameter int SOFT_ADDR   = 'h50,
  parameter int CTRL_ADDR   = 'h60,
  localparam int NENT       = NCH * NBANK,
  localparam int BW         = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_in,
  input  logic [BW-1:0]     bank_pin,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [CW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [CW-1:0]     rsp_data,
  output logic [NCH*CW-1:0] code_out
);
  logic                load_s;
  logic [BW-1:0]       pin_s;
  logic [NENT*CW-1:0]  bank_flat;
  logic [NCH*CW-1:0]   direct_flat;
  logic [NCH*CW-1:0]   sel_flat;
  logic [BW-1:0]       soft_sel;
  logic [1:0]          mode_bits;

  assign req_ready = 1'b1;

  gbc_sync #(.W(1 + BW), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({load_in, bank_pin}),
    .q({load_s, pin_s})
  );

  gbc_regfile #(
    .NCH(NCH), .CW(CW), .NBANK(NBANK), .AW(AW),
    .DIRECT_BASE(DIRECT_BASE), .BANK_BASE(BANK_BASE),
    .SOFT_ADDR(SOFT_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bank_flat(bank_flat), .direct_flat(direct_flat),
    .soft_sel(soft_sel), .mode_bits(mode_bits)
  );

  gbc_select #(.NCH(NCH), .CW(CW), .NBANK(NBANK)) sel_i (
    .mode_bits(mode_bits), .pin_sel(pin_s), .soft_sel(soft_sel),
    .bank_flat(bank_flat), .direct_flat(direct_flat),
    .sel_flat(sel_flat)
  );

  gbc_hold #(.NCH(NCH), .CW(CW)) hold_i (
    .clk(clk), .rst_n(rst_n), .load_s(load_s),
    .sel_flat(sel_flat), .code_flat(code_out)
  );
endmodule

// File: rtl/gbc_checker.sv
module gbc_checker #(
  parameter int NCH       = 11,
  parameter int CW        = 8,
  parameter int AW        = 8,
  parameter int SOFT_ADDR = 'h50,
  parameter int CTRL_ADDR = 'h60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_s,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic              rsp_valid,
  input logic [CW-1:0]     rsp_data,
  input logic [NCH*CW-1:0] code_out
);
  logic unmapped_rd;
  assign unmapped_rd = req_valid && !req_write &&
    (((req_addr >= AW'('h0B)) && (req_addr <= AW'('h0F))) ||
     ((req_addr >= AW'('h3C)) && (req_addr <= AW'('h4F))) ||
     (req_addr == AW'('h70)));

  // R8: the held codes move only on a cycle after synchronized load was high
  p_hold_when_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_s) |-> $stable(code_out));

  // R10: each accepted read is answered exactly one cycle later
  p_rsp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && req_ready && !req_write));

  // R10: request side never back-pressures
  p_ready_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_ready);

  // R5: soft select reads carry zeros above bit 1
  p_soft_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write && req_addr == AW'(SOFT_ADDR))
      |-> rsp_data[CW-1:2] == '0);

  // R2: control reads carry zeros above bit 1
  p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write && req_addr == AW'(CTRL_ADDR))
      |-> rsp_data[CW-1:2] == '0);

  // R11: holes in the map read as zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unmapped_rd) |-> rsp_data == '0);
endmodule

bind gamma_bank_ctrl gbc_checker #(
  .NCH(NCH), .CW(CW), .AW(AW), .SOFT_ADDR(SOFT_ADDR), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .load_s(load_s),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .code_out(code_out)
);

// File: tb/gamma_bank_ctrl_tb_top.sv
module gamma_bank_ctrl_tb_top;
  localparam int NCH = 11;
  localparam int CW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_in = 1'b0;
  logic [1:0]    bank_pin = 2'd0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          rsp_valid;
  logic [7:0]    rsp_data;
  logic [NCH*CW-1:0] code_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gamma_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .load_in(load_in), .bank_pin(bank_pin),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .code_out(code_out)
  );

  function automatic logic [7:0] bank_val(input int n, input int b);
    return 8'((n * 37 + b * 71 + 5) % 256);
  endfunction
  function automatic logic [7:0] dir_val(input int n, input int salt);
    return 8'((n * 13 + 160 + salt) % 256);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data; v = rsp_valid;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d; logic v;
    reg_read(a, d, v);
    check({req, " rsp_valid"}, 32'(v), 32'd1);
    check(req, 32'(d), 32'(exp));
  endtask

  // kind 0: bank b; kind 1: direct with salt b
  task automatic check_codes(input string req, input int kind, input int b);
    for (int n = 0; n < NCH; n++) begin
      logic [7:0] e;
      e = (kind == 0) ? bank_val(n, b) : dir_val(n, b);
      check(req, 32'(code_out[n*CW +: CW]), 32'(e));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d; logic v;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);

    // R1: reset state
    check("R1 code_out", 32'(code_out == '0), 32'd1);
    read_check("R1 ctrl", 8'h60, 8'h00);
    read_check("R1 soft", 8'h50, 8'h00);
    read_check("R1 bank", 8'h10, 8'h00);
    check("R10 ready", 32'(req_ready), 32'd1);

    // R3/R10: fill and read back every stored byte
    for (int n = 0; n < NCH; n++) begin
      for (int b = 0; b < 4; b++) reg_write(8'(8'h10 + 4*n + b), bank_val(n, b));
      reg_write(8'(n), dir_val(n, 0));
    end
    for (int n = 0; n < NCH; n++) begin
      for (int b = 0; b < 4; b++) read_check("R3 bank readback", 8'(8'h10 + 4*n + b), bank_val(n, b));
      read_check("R10 direct readback", 8'(n), dir_val(n, 0));
    end

    // R10: no response without a read
    cycles(1);
    check("R10 idle rsp_valid", 32'(rsp_valid), 32'd0);

    // R11: holes read zero, writes there are dropped
    reg_write(8'h0C, 8'h5A);
    reg_write(8'h70, 8'hA5);
    reg_write(8'h3C, 8'h77);
    read_check("R11 hole 0C", 8'h0C, 8'h00);
    read_check("R11 hole 70", 8'h70, 8'h00);
    read_check("R11 hole 3C", 8'h3C, 8'h00);
    read_check("R11 neighbour intact", 8'h3B, bank_val(10, 3));

    // R8: load still low, nothing moved
    check("R8 code_out held at zero", 32'(code_out == '0), 32'd1);

    // R4/R3: pin mode sweep with soft register set elsewhere
    reg_write(8'h50, 8'h03);
    load_in = 1'b1;
    for (int p = 0; p < 4; p++) begin
      bank_pin = 2'(p);
      cycles(5);
      check_codes("R4 pin bank", 0, p);
    end

    // R7: exact latency of a pin change
    bank_pin = 2'd1;
    cycles(5);
    @(negedge clk); bank_pin = 2'd2;
    @(negedge clk);
    @(negedge clk);
    check("R7 before third edge", 32'(code_out[7:0]), 32'(bank_val(0, 1)));
    @(negedge clk);
    check("R7 at third edge", 32'(code_out[7:0]), 32'(bank_val(0, 2)));

    // R2: MODE0 ignored while MODE1 clear
    reg_write(8'h60, 8'h01);
    bank_pin = 2'd0;
    cycles(5);
    check_codes("R2 mode 01 is pin", 0, 0);
    read_check("R2 ctrl readback", 8'h60, 8'h01);
    reg_write(8'h60, 8'hFE);
    read_check("R2 ctrl keeps two bits", 8'h60, 8'h02);

    // R5: soft mode sweep with pins held on a different bank
    for (int s = 0; s < 4; s++) begin
      reg_write(8'h50, 8'(s));
      bank_pin = 2'(3 - s);
      cycles(5);
      check_codes("R5 soft bank", 0, s);
    end
    reg_write(8'h50, 8'hFE);
    read_check("R5 soft keeps two bits", 8'h50, 8'h02);

    // R6: direct mode, bank selection irrelevant
    reg_write(8'h60, 8'h03);
    cycles(3);
    check_codes("R6 direct", 1, 0);
    bank_pin = 2'd1;
    reg_write(8'h50, 8'h01);
    cycles(5);
    check_codes("R6 direct ignores banks", 1, 0);

    // R8/R9: lower load, then disturb the selection
    load_in = 1'b0;
    cycles(5);
    for (int n = 0; n < NCH; n++) reg_write(8'(n), dir_val(n, 7));
    reg_write(8'h60, 8'h00);
    bank_pin = 2'd3;
    cycles(6);
    check_codes("R8 held while load low", 1, 0);
    load_in = 1'b1;
    cycles(5);
    check_codes("R9 resume after rise (pin bank D)", 0, 3);

    // R9: capture at fall, in pin mode
    bank_pin = 2'd2;
    cycles(5);
    load_in = 1'b0;
    cycles(5);
    bank_pin = 2'd0;
    cycles(5);
    check_codes("R9 captured bank C", 0, 2);
    reg_write(8'h60, 8'h03);
    cycles(3);
    check_codes("R8 mode change while low", 0, 2);
    load_in = 1'b1;
    cycles(5);
    check_codes("R9 direct after rise", 1, 7);

    // R1: reset again mid-run clears outputs and registers
    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    load_in = 1'b0;
    cycles(4);
    check("R1 code_out after reset", 32'(code_out == '0), 32'd1);
    reg_read(8'h60, d, v);
    check("R1 ctrl after reset", 32'(d), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule